// File: doc/BRIEF.md
# Grouped interrupt event aggregator

This block keeps a 32-bit event word and a 32-bit enable word behind a small register port. Internal sources raise single-cycle set pulses that latch into the event word. Software reads either word, clears event bits by writing ones to the event address, and loads the enable word with a plain write.

The enabled events are the event word ANDed with the enable word. Three level interrupt lines come out of the block: transmit, receive and error. Each line is the OR of the enabled events that fall inside its own group mask, and the group masks are parameters. The lines are registered, so each one follows a change in either word by one clock.

Top module: `irq_group_agg`

## Requirements
- R1: After reset the event word and the enable word read as zero, and all three interrupt lines are low.
- R2: A set pulse on bit i of `evt_set_i` makes event bit i read as 1 from the next cycle, and the bit stays 1 until software clears it.
- R3: A write to the event address (`reg_addr_i` = 0) clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A write to the enable address (`reg_addr_i` = 1) replaces the whole enable word. It has no effect on the event word.
- R5: When a set pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R6: Each interrupt line equals the OR over (event AND enable AND its group mask). The line is registered, so it reflects the register values present one cycle earlier.
- R7: An event bit that lies outside all three group masks never raises any interrupt line, whatever the enable word holds.
- R8: Read data is combinational: address 0 returns the event word and address 1 returns the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_set_i | input | 32 | Per-bit event set pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects the event word, 1 selects the enable word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_tx_o | output | 1 | Transmit group interrupt |
| irq_rx_o | output | 1 | Receive group interrupt |
| irq_err_o | output | 1 | Error group interrupt |

## Verification
The bench builds the block with its default groups:
- transmit on bits 7:0
- receive on bits 15:8
- error on bits 23:16 and bit 31

Bits 30:24 belong to no group. This layout lets one stimulus separate the three lines, and it leaves a whole range of bits outside every group for the R7 check. Bit 31 sits alone in the error group, which shows that a group mask does not have to be contiguous.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NGRP = 3;
  typedef enum logic [1:0] {GRP_TX = 2'd0, GRP_RX = 2'd1, GRP_ERR = 2'd2} grp_e;
  localparam logic [DW-1:0] DEF_TX_MASK  = 32'h0000_00FF;
  localparam logic [DW-1:0] DEF_RX_MASK  = 32'h0000_FF00;
  localparam logic [DW-1:0] DEF_ERR_MASK = 32'h80FF_0000;
endpackage

// File: rtl/irq_evt_reg.sv
module irq_evt_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] clr_eff;
  // set has priority over a same-cycle clear
  assign clr_eff = clr_we_i ? (clr_i & ~set_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_eff) | set_i;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_grp_reduce.sv
module irq_grp_reduce #(
  parameter int unsigned DW = 32,
  parameter int unsigned NGRP = 3,
  parameter logic [NGRP*DW-1:0] GRP_MASKS = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   active_i,
  output logic [NGRP-1:0] irq_o
);
  logic [NGRP-1:0] irq_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [DW-1:0] GM = GRP_MASKS[g*DW +: DW];
    assign irq_d[g] = |(active_i & GM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_group_pkg::*;
#(
  parameter logic [31:0] TX_MASK  = DEF_TX_MASK,
  parameter logic [31:0] RX_MASK  = DEF_RX_MASK,
  parameter logic [31:0] ERR_MASK = DEF_ERR_MASK
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] evt_set_i,
  input  logic        reg_we_i,
  input  logic        reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_tx_o,
  output logic        irq_rx_o,
  output logic        irq_err_o
);
  localparam logic [NGRP*DW-1:0] GRP_MASKS = {ERR_MASK, RX_MASK, TX_MASK};

  logic [DW-1:0]   evt_q, msk_q, active;
  logic [NGRP-1:0] irq_q;

  irq_evt_reg #(.DW(DW)) u_evt (
    .clk_i, .rst_ni,
    .set_i    (evt_set_i),
    .clr_we_i (reg_we_i && !reg_addr_i),
    .clr_i    (reg_wdata_i),
    .q_o      (evt_q)
  );

  irq_mask_reg #(.DW(DW)) u_msk (
    .clk_i, .rst_ni,
    .we_i (reg_we_i && reg_addr_i),
    .d_i  (reg_wdata_i),
    .q_o  (msk_q)
  );

  assign active = evt_q & msk_q;

  irq_grp_reduce #(.DW(DW), .NGRP(NGRP), .GRP_MASKS(GRP_MASKS)) u_red (
    .clk_i, .rst_ni,
    .active_i (active),
    .irq_o    (irq_q)
  );

  assign reg_rdata_o = reg_addr_i ? msk_q : evt_q;
  assign irq_tx_o  = irq_q[GRP_TX];
  assign irq_rx_o  = irq_q[GRP_RX];
  assign irq_err_o = irq_q[GRP_ERR];
endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk #(
  parameter logic [31:0] TX_MASK  = 32'h0,
  parameter logic [31:0] RX_MASK  = 32'h0,
  parameter logic [31:0] ERR_MASK = 32'h0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] evt_set_i,
  input logic        reg_we_i,
  input logic        reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] evt_q,
  input logic [31:0] msk_q,
  input logic        irq_tx_o,
  input logic        irq_rx_o,
  input logic        irq_err_o
);
  a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_set_i != 0) |=> ((evt_q & $past(evt_set_i)) == $past(evt_set_i)));

  a_r3_clear_only_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=>
      (evt_q == (($past(evt_q) & ~$past(reg_wdata_i)) | $past(evt_set_i))));

  a_r4_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i) |=> (msk_q == $past(reg_wdata_i)));

  a_r4_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i) |=> $stable(msk_q));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && ((evt_set_i & reg_wdata_i) != 0)) |=>
      ((evt_q & $past(evt_set_i & reg_wdata_i)) == $past(evt_set_i & reg_wdata_i)));

  a_r6_tx_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_tx_o == |($past(evt_q & msk_q) & TX_MASK)));

  a_r6_rx_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_rx_o == |($past(evt_q & msk_q) & RX_MASK)));

  a_r6_err_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_err_o == |($past(evt_q & msk_q) & ERR_MASK)));
endmodule

bind irq_group_agg irq_group_agg_chk #(
  .TX_MASK(TX_MASK), .RX_MASK(RX_MASK), .ERR_MASK(ERR_MASK)
) u_chk (
  .clk_i, .rst_ni, .evt_set_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .evt_q, .msk_q, .irq_tx_o, .irq_rx_o, .irq_err_o
);

// File: tb/irq_group_agg_bench.sv
`timescale 1ns/1ps
module irq_group_agg_bench;
  localparam logic [31:0] TXM  = 32'h0000_00FF;
  localparam logic [31:0] RXM  = 32'h0000_FF00;
  localparam logic [31:0] ERRM = 32'h80FF_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] evt_set = '0, wdata = '0, rdata;
  logic we = 0, addr = 0;
  logic irq_tx, irq_rx, irq_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_group_agg u_irq_group_agg (
    .clk_i(clk), .rst_ni(rst_n), .evt_set_i(evt_set), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with given inputs; inputs return idle after
  task automatic cyc(logic [31:0] s, logic w, logic a, logic [31:0] d);
    evt_set = s; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    evt_set = '0; we = 0; wdata = '0;
  endtask

  function automatic logic [2:0] exp_irq(logic [31:0] e, logic [31:0] m);
    return {|(e & m & ERRM), |(e & m & RXM), |(e & m & TXM)};
  endfunction

  task automatic rd(output logic [31:0] v, input logic a);
    addr = a; #1; v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v, 0); chk("R1 evt", v, 0);
    rd(v, 1); chk("R1 msk", v, 0);
    chk("R1 irq", {irq_err, irq_rx, irq_tx}, 0);
  endtask

  task automatic t_set_mask();
    logic [31:0] v;
    cyc(32'h0000_0104, 0, 0, 0);
    rd(v, 0); chk("R2 set", v, 32'h0000_0104);
    chk("R6 masked off", {irq_err, irq_rx, irq_tx}, 0);
    cyc(0, 1, 1, 32'h0000_0004);
    rd(v, 1); chk("R4 load", v, 32'h4);
    rd(v, 0); chk("R4 evt untouched", v, 32'h0000_0104);
    chk("R6 not yet", {irq_err, irq_rx, irq_tx}, 0);
    @(posedge clk); #1;
    chk("R6 tx", {irq_err, irq_rx, irq_tx}, 3'b001);
    cyc(0, 1, 1, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    chk("R6 tx+rx", {irq_err, irq_rx, irq_tx}, exp_irq(32'h104, 32'hFFFF_FFFF));
    cyc(0, 0, 0, 0);
    rd(v, 0); chk("R2 hold", v, 32'h0000_0104);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    cyc(0, 1, 0, 32'h0000_0004);
    rd(v, 0); chk("R3 partial clear", v, 32'h0000_0100);
    @(posedge clk); #1;
    chk("R3 tx dropped", {irq_err, irq_rx, irq_tx}, 3'b010);
    cyc(0, 1, 0, 32'hFFFF_FFFF);
    rd(v, 0); chk("R3 full clear", v, 0);
    @(posedge clk); #1;
    chk("R3 irq low", {irq_err, irq_rx, irq_tx}, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    cyc(32'h8000_0001, 1, 0, 32'h8000_0003);
    rd(v, 0); chk("R5 set wins", v, 32'h8000_0001);
    @(posedge clk); #1;
    chk("R5 irq", {irq_err, irq_rx, irq_tx}, 3'b101);
    cyc(0, 1, 0, 32'hFFFF_FFFF);
    @(posedge clk); #1;
  endtask

  task automatic t_orphan();
    logic [31:0] v;
    cyc(32'h7F00_0000, 0, 0, 0);
    rd(v, 0); chk("R7 orphan latched", v, 32'h7F00_0000);
    @(posedge clk); #1;
    chk("R7 no irq", {irq_err, irq_rx, irq_tx}, 0);
    cyc(32'h0001_0000, 0, 0, 0);
    @(posedge clk); #1;
    chk("R7 err only", {irq_err, irq_rx, irq_tx}, 3'b100);
    addr = 1; #1; chk("R8 rd mask", rdata, 32'hFFFF_FFFF);
    addr = 0; #1; chk("R8 rd evt", rdata, 32'h7F01_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_set_mask();
    t_clear();
    t_set_wins();
    t_orphan();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog"); end
    join_any
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule